// File: doc/BRIEF.md
# Sparse Run Encoder

This block compresses one row of a 64-column pixel group into a short list of hit strings. A string is a group of adjacent hit columns. The block takes a latched row of discriminator bits and a group address under a load strobe. It then walks the row from column 0 upward. On each step it takes the lowest remaining hit, measures the string that starts there (at most four pixels), records it as an 8-bit state word and removes it from the row. Six such steps run, one per clock, whatever the row holds, so every row costs the same number of cycles.

When the scan ends, the block presents the following, all held until the next accepted load:

- up to six state words,
- a 3-bit count of valid words,
- an overflow flag, raised when hits were left over,
- the captured group address,
- a one-cycle done pulse.

A string longer than four pixels is cut. The first four columns become one state, and the scan picks up again at the next column. A downstream multiplexer and memory writer use the outputs to build a frame stream that covers fifteen such groups per row.

Top module: `sparse_run_encoder`

## Requirements
- R1: After reset, done and busy are low, and stateWords, stateCount, overflow and groupAddrOut are all zero.
- R2: A load strobe sampled high at a clock edge while the block is idle starts a scan. busy is high from the next cycle. done is high for exactly one cycle, beginning after the seventh rising edge counted from the load edge (the load edge plus six scan edges).
- R3: State word i sits at stateWords[8*i+7:8*i]. Bits 7:2 hold the column of the first pixel of the string, and bits 1:0 hold the string length minus one. Slot 0 holds the lowest column, and the slots rise in column order.
- R4: A string of more than four adjacent hits is emitted as a four-pixel state (code 3). The columns after it are encoded as further states, starting at the next column.
- R5: At most six states are stored. stateCount is 0 to 6 and equals the number of valid slots.
- R6: overflow is 1 exactly when the row holds hits that are not covered by the six stored states. Otherwise it is 0.
- R7: Every slot at or above stateCount reads as zero.
- R8: groupAddrOut equals the groupAddr value present at the accepted load edge.
- R9: A load strobe raised while a scan is in progress is ignored. It neither restarts nor alters the scan.
- R10: After done, all outputs hold their values until the next accepted load.
- R11: Strings that touch column 63 are encoded with their true length, cut off at the group edge (for example, hits at 62 and 63 give column 62, code 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadRow | input | 1 | Load strobe for a new row |
| rowBits | input | 64 | Discriminator bits of the group, bit n is column n |
| groupAddr | input | 5 | Address of the group being loaded |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse, outputs are valid |
| stateWords | output | 48 | Six packed state words, slot 0 in the low byte |
| stateCount | output | 3 | Number of valid state words |
| overflow | output | 1 | Hits remained after six states |
| groupAddrOut | output | 5 | Group address captured at load |

## Verification
The bench aims at the corners where a scan most easily goes wrong:

- **A string longer than four pixels.** A design that fails to cut it would emit a single state with a wrapped length code.
- **Strings at column 63.** A design that fails here would read past the edge or drop the last pixel.
- **Six versus seven isolated hits.** An off-by-one in the slot limit would show up as a wrong overflow flag or a corrupted seventh write.
- **A fully hit row.** This one must overflow after six four-pixel states.
- **A load strobe raised mid-scan.** A design that honoured it would restart the scan and finish with the wrong row.

Random rows at several densities are compared against a column-walking model.

// File: rtl/sre_pkg.sv
package sre_pkg;

  // Strobes issued by the sequencer to the datapath each cycle
  typedef struct packed {
    logic capture;  // latch a new row and clear the results
    logic step;     // perform one find-and-remove iteration
    logic finish;   // this step is the last one of the scan
  } seqStrobes_t;

endpackage

// File: rtl/sre_run_finder.sv
// Combinational: lowest set bit of the remaining row, length of the string
// starting there (capped at MAX_RUN), and the mask that removes it.
module sre_run_finder #(
  parameter int GROUP_W = 64,
  parameter int MAX_RUN = 4,
  localparam int COL_W  = $clog2(GROUP_W),
  localparam int LEN_W  = $clog2(MAX_RUN)
) (
  input  logic [GROUP_W-1:0] row,
  output logic               found,
  output logic [COL_W-1:0]   col,
  output logic [LEN_W-1:0]   lenCode,
  output logic [GROUP_W-1:0] clearMask
);

  logic [MAX_RUN-1:0] window;
  logic [GROUP_W-1:0] lenMask;
  logic               contig;

  // Priority pick of the lowest hit column
  always_comb begin
    found = |row;
    col   = '0;
    for (int i = GROUP_W - 1; i >= 0; i--) begin
      if (row[i]) col = COL_W'(i);
    end
  end

  // Length of the string: count adjacent ones from the first hit, capped
  always_comb begin
    window  = MAX_RUN'(row >> col);
    contig  = 1'b1;
    lenCode = '0;
    for (int k = 1; k < MAX_RUN; k++) begin
      contig = contig & window[k];
      if (contig) lenCode = LEN_W'(k);
    end
  end

  // Mask covering the encoded pixels only
  always_comb begin
    lenMask = '0;
    for (int k = 0; k < MAX_RUN; k++) begin
      if (k <= int'(lenCode)) lenMask[k] = 1'b1;
    end
    clearMask = lenMask << col;
  end

endmodule

// File: rtl/sre_ctrl.sv
// Sequencer: idle until a load, then a fixed number of scan steps, then done.
module sre_ctrl
  import sre_pkg::*;
#(
  parameter int MAX_STATES = 6,
  localparam int ITER_W    = (MAX_STATES > 1) ? $clog2(MAX_STATES) : 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadRow,
  output seqStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  typedef enum logic {ST_IDLE, ST_SCAN} seqState_t;

  seqState_t         state;
  logic [ITER_W-1:0] iterCnt;

  always_comb begin
    strobes.capture = loadRow && (state == ST_IDLE);
    strobes.step    = (state == ST_SCAN);
    strobes.finish  = (state == ST_SCAN) && (iterCnt == ITER_W'(MAX_STATES - 1));
  end

  assign busy = (state == ST_SCAN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (loadRow) begin
            state   <= ST_SCAN;
            iterCnt <= '0;
          end
        end
        ST_SCAN: begin
          iterCnt <= iterCnt + 1'b1;
          if (strobes.finish) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && loadRow) |=> busy); // R2

  AST_SCAN_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobes.finish) |=> (busy && iterCnt == ITER_W'($past(iterCnt) + 1'b1))); // R9

  AST_DONE_ENDS_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R2

endmodule

// File: rtl/sre_datapath.sv
// Working row, state slots, count, overflow and captured group address.
module sre_datapath
  import sre_pkg::*;
#(
  parameter int GROUP_W    = 64,
  parameter int MAX_STATES = 6,
  parameter int MAX_RUN    = 4,
  parameter int ADDR_W     = 5,
  localparam int COL_W     = $clog2(GROUP_W),
  localparam int LEN_W     = $clog2(MAX_RUN),
  localparam int WORD_W    = COL_W + LEN_W,
  localparam int CNT_W     = $clog2(MAX_STATES + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqStrobes_t                  strobes,
  input  logic [GROUP_W-1:0]           rowBits,
  input  logic [ADDR_W-1:0]            groupAddr,
  output logic [MAX_STATES*WORD_W-1:0] stateWords,
  output logic [CNT_W-1:0]             stateCount,
  output logic                         overflow,
  output logic [ADDR_W-1:0]            groupAddrOut
);

  logic [GROUP_W-1:0] workRow;
  logic [GROUP_W-1:0] nextRow;
  logic [WORD_W-1:0]  slot [MAX_STATES];
  logic [CNT_W-1:0]   cnt;
  logic               ovf;
  logic [ADDR_W-1:0]  addrReg;

  logic               hitFound;
  logic [COL_W-1:0]   hitCol;
  logic [LEN_W-1:0]   hitLen;
  logic [GROUP_W-1:0] hitMask;

  sre_run_finder #(
    .GROUP_W (GROUP_W),
    .MAX_RUN (MAX_RUN)
  ) uFinder (
    .row       (workRow),
    .found     (hitFound),
    .col       (hitCol),
    .lenCode   (hitLen),
    .clearMask (hitMask)
  );

  assign nextRow = hitFound ? (workRow & ~hitMask) : workRow;

  // Row and bookkeeping of found states
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workRow <= '0;
      cnt     <= '0;
      ovf     <= 1'b0;
      addrReg <= '0;
    end else if (strobes.capture) begin
      workRow <= rowBits;
      cnt     <= '0;
      ovf     <= 1'b0;
      addrReg <= groupAddr;
    end else if (strobes.step) begin
      workRow <= nextRow;
      if (hitFound) cnt <= cnt + 1'b1;
      if (strobes.finish) ovf <= |nextRow;
    end
  end

  // One register per slot, written when the count points at it
  for (genvar i = 0; i < MAX_STATES; i++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slot[i] <= '0;
      end else if (strobes.capture) begin
        slot[i] <= '0;
      end else if (strobes.step && hitFound && (cnt == CNT_W'(i))) begin
        slot[i] <= {hitCol, hitLen};
      end
    end

    assign stateWords[i*WORD_W +: WORD_W] = slot[i];

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (cnt <= CNT_W'(i)) |-> (slot[i] == '0)); // R7
  end

  assign stateCount   = cnt;
  assign overflow     = ovf;
  assign groupAddrOut = addrReg;

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(MAX_STATES)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ovf |-> (cnt == CNT_W'(MAX_STATES))); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capture && !strobes.step) |=> ($stable(cnt) && $stable(ovf) && $stable(addrReg) && $stable(stateWords))); // R10

  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (addrReg == $past(groupAddr))); // R8

endmodule

// File: rtl/sparse_run_encoder.sv
// Top: sequencer plus datapath.
module sparse_run_encoder
  import sre_pkg::*;
#(
  parameter int GROUP_W    = 64,
  parameter int MAX_STATES = 6,
  parameter int MAX_RUN    = 4,
  parameter int ADDR_W     = 5,
  localparam int COL_W     = $clog2(GROUP_W),
  localparam int LEN_W     = $clog2(MAX_RUN),
  localparam int WORD_W    = COL_W + LEN_W,
  localparam int CNT_W     = $clog2(MAX_STATES + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         loadRow,
  input  logic [GROUP_W-1:0]           rowBits,
  input  logic [ADDR_W-1:0]            groupAddr,
  output logic                         busy,
  output logic                         done,
  output logic [MAX_STATES*WORD_W-1:0] stateWords,
  output logic [CNT_W-1:0]             stateCount,
  output logic                         overflow,
  output logic [ADDR_W-1:0]            groupAddrOut
);

  seqStrobes_t strobes;

  sre_ctrl #(
    .MAX_STATES (MAX_STATES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadRow (loadRow),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  sre_datapath #(
    .GROUP_W    (GROUP_W),
    .MAX_STATES (MAX_STATES),
    .MAX_RUN    (MAX_RUN),
    .ADDR_W     (ADDR_W)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .rowBits      (rowBits),
    .groupAddr    (groupAddr),
    .stateWords   (stateWords),
    .stateCount   (stateCount),
    .overflow     (overflow),
    .groupAddrOut (groupAddrOut)
  );

endmodule

// File: tb/sparse_run_encoder_test.sv
`timescale 1ns/1ps
module sparse_run_encoder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadRow = 1'b0;
  logic [63:0] rowBits = '0;
  logic [4:0]  groupAddr = '0;
  logic        busy, done, overflow;
  logic [47:0] stateWords;
  logic [2:0]  stateCount;
  logic [4:0]  groupAddrOut;

  int testsRun = 0;
  int testsFailed = 0;
  int seedDummy;

  always #2 clk = ~clk;  // 250 MHz

  sparse_run_encoder uut (
    .clk(clk), .rstN(rstN), .loadRow(loadRow), .rowBits(rowBits),
    .groupAddr(groupAddr), .busy(busy), .done(done), .stateWords(stateWords),
    .stateCount(stateCount), .overflow(overflow), .groupAddrOut(groupAddrOut)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Column-walking reference: strings capped at 4, first 6 kept
  function automatic void model(input logic [63:0] r, output logic [47:0] w,
                                output int n, output bit ov);
    int c = 0;
    int total = 0;
    w = '0;
    ov = 0;
    while (c < 64) begin
      if (r[c]) begin
        int len = 0;
        while ((c + len) < 64 && len < 4 && r[c + len]) len++;
        if (total < 6) w[total*8 +: 8] = {6'(c), 2'(len - 1)};
        else ov = 1;
        total++;
        c += len;
      end else begin
        c++;
      end
    end
    n = (total > 6) ? 6 : total;
  endfunction

  // Load a row, optionally poke load mid-scan, then check all outputs
  task automatic runRow(input logic [63:0] r, input logic [4:0] a,
                        input string tag, input bit pokeLoad);
    logic [47:0] expW;
    int expN;
    bit expOv;
    bit earlyDone = 0;
    model(r, expW, expN, expOv);
    @(negedge clk);
    loadRow = 1'b1; rowBits = r; groupAddr = a;
    @(negedge clk);
    loadRow = 1'b0;
    check(busy === 1'b1, "R2 busy after load", 64'(busy), 64'd1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (done !== 1'b0) earlyDone = 1;
      if (pokeLoad && k == 1) begin
        loadRow = 1'b1; rowBits = ~r; groupAddr = ~a;
      end
      if (pokeLoad && k == 3) loadRow = 1'b0;
    end
    @(negedge clk);
    loadRow = 1'b0;
    check(!earlyDone && done === 1'b1, "R2 done timing", 64'(done), 64'd1);
    check(stateWords === expW, pokeLoad ? "R9 words after mid-scan load" : tag,
          64'(stateWords), 64'(expW));
    check(stateCount === 3'(expN), "R5 count", 64'(stateCount), 64'(expN));
    check(overflow === expOv, "R6 overflow", 64'(overflow), 64'(expOv));
    check(groupAddrOut === a, "R8 group address", 64'(groupAddrOut), 64'(a));
    for (int s = 0; s < 6; s++) begin
      if (s >= expN)
        check(stateWords[s*8 +: 8] === 8'd0, "R7 unused slot zero",
              64'(stateWords[s*8 +: 8]), 64'd0);
    end
    @(negedge clk);
    check(done === 1'b0, "R2 done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", testsRun, 0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [47:0] holdW;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done === 1'b0 && busy === 1'b0, "R1 reset control", {busy, done}, 64'd0);
    check(stateWords === '0 && stateCount === '0 && overflow === 1'b0 &&
          groupAddrOut === '0, "R1 reset outputs", 64'(stateWords), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed corners
    runRow(64'd0, 5'd1, "R3 empty row", 0);
    runRow(64'h0000_0000_0000_0019, 5'd2, "R3 two strings ordered", 0);
    runRow(64'h0000_0000_0000_001F, 5'd3, "R4 string of five split", 0);
    runRow(64'h0000_0000_0000_FFFF, 5'd4, "R4 string of sixteen split", 0);
    runRow(64'hFFFF_FFFF_FFFF_FFFF, 5'd31, "R6 full row overflow", 0);
    runRow(64'h0000_0000_0000_0555, 5'd5, "R5 six isolated no overflow", 0);
    runRow(64'h0000_0000_0000_1555, 5'd6, "R6 seven isolated overflow", 0);
    runRow(64'h8000_0000_0000_0000, 5'd7, "R11 single hit at 63", 0);
    runRow(64'hC000_0000_0000_0000, 5'd8, "R11 pair at 62..63", 0);
    runRow(64'hF800_0000_0000_0000, 5'd9, "R11 five at 59..63", 0);
    runRow(64'h0000_0000_00F0_F0F1, 5'd10, "R9 poke", 1);

    // R10: outputs hold after done
    holdW = stateWords;
    repeat (8) @(negedge clk);
    check(stateWords === holdW && done === 1'b0, "R10 outputs hold",
          64'(stateWords), 64'(holdW));

    // Random rows at several densities
    for (int t = 0; t < 400; t++) begin
      logic [63:0] r;
      logic [63:0] a2;
      logic [63:0] b2;
      a2 = {$urandom, $urandom};
      b2 = {$urandom, $urandom};
      case (t % 4)
        0: r = a2 & b2 & {$urandom, $urandom};
        1: r = a2 & b2;
        2: r = a2;
        default: r = a2 | b2;
      endcase
      runRow(r, 5'($urandom), "R3 random row words", (t % 25) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule